// File: doc/BRIEF.md
# Paired Channel Loopback Router

This block sits between a bank of timer channel cores and their pads. It routes a signal from one channel to the other channel of a fixed pair, so that one channel can measure a waveform its neighbour produces, such as the period or duty of a PWM. Channels 2x and 2x+1 form pair x. Each pair has three registered control bits: an enable bit, a direction bit that picks which channel drives, and a type bit.

The type bit picks between two paths. The digital path feeds the driving core's output value straight into the receiving channel's capture input and keeps both pads undriven. The pad path drives the value out through the driving channel's output buffer and then captures the pin level on the receiving side, so the waveform can still be seen outside the chip. The data path is purely combinational. Only the control bits pass through registers. The controls are loaded together on a write strobe.

Top module: `pair_loopback_router`

## Requirements
- R1: Pair x covers only channels 2x and 2x+1. The controls of one pair never change the capture, pad value or pad enable of channels in another pair.
- R2: With the pair's enable bit at 0, each channel's capture input equals its own pad input and its pad enable equals its own core output enable. In every mode, each pad's drive value equals its own core output value.
- R3: The direction bit picks the roles. At 0 the odd channel drives and the even channel receives. At 1 the even channel drives and the odd channel receives.
- R4: With enable 1 and type 0 (digital), the receiving channel's capture input equals the driving channel's core output value in the same cycle.
- R5: With enable 1 and type 0, both pad enables of the pair are 0.
- R6: With enable 1 and type 1 (pad path), the driving channel's pad enable is 1 and the receiving channel's pad enable is 0. The receiving channel's capture input equals the driving channel's pad input.
- R7: In either loopback type, the driving channel's capture input equals its own pad input.
- R8: Control bits load from the write inputs on a rising clock edge where the write strobe is 1, and take effect right after that edge. While the strobe is 0, changes on the write inputs have no effect.
- R9: Reset clears every enable, direction and type bit. The router then behaves as in R2 for all channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Load strobe for the control bits |
| cfg_en | input | NPAIRS | Enable bits to load, one per pair |
| cfg_dir | input | NPAIRS | Direction bits to load (1 = even channel drives) |
| cfg_type | input | NPAIRS | Type bits to load (1 = pad path) |
| core_out | input | 2*NPAIRS | Output value of each channel core |
| core_oe | input | 2*NPAIRS | Output enable of each channel core |
| pad_in | input | 2*NPAIRS | Level received from each pad |
| cap_in | output | 2*NPAIRS | Capture input given to each channel core |
| pad_out | output | 2*NPAIRS | Value driven toward each pad |
| pad_oe | output | 2*NPAIRS | Output enable of each pad buffer |

## Verification
A control write takes effect one clock edge after its strobe: the outputs reflect the new bits right after that rising edge. Data inputs reach the outputs within the same cycle, with no clock edge between them. The bench changes all inputs on the falling edge and lets one rising edge pass, so a pending write lands. It then samples 2 ns later and compares the outputs against a bench model of the control bits and the routing. This interval covers both the registered and the combinational results. Directed steps check that writes without the strobe leave the state unchanged, and that one pair's controls stay out of its neighbour's channels.

// File: rtl/pair_loopback_router.sv
module pair_loopback_router #(
  parameter int NPAIRS = 4,
  localparam int NCH = 2 * NPAIRS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [NPAIRS-1:0] cfg_en,
  input  logic [NPAIRS-1:0] cfg_dir,
  input  logic [NPAIRS-1:0] cfg_type,
  input  logic [NCH-1:0]    core_out,
  input  logic [NCH-1:0]    core_oe,
  input  logic [NCH-1:0]    pad_in,
  output logic [NCH-1:0]    cap_in,
  output logic [NCH-1:0]    pad_out,
  output logic [NCH-1:0]    pad_oe
);

  logic [NPAIRS-1:0] en_q, dir_q, type_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      dir_q  <= '0;
      type_q <= '0;
    end else if (cfg_wr) begin
      en_q   <= cfg_en;
      dir_q  <= cfg_dir;
      type_q <= cfg_type;
    end
  end

  assign pad_out = core_out;

  for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
    localparam int EV = 2 * p;
    localparam int OD = 2 * p + 1;
    logic drv_val, drv_pin, loop_val;

    assign drv_val  = dir_q[p] ? core_out[EV] : core_out[OD];
    assign drv_pin  = dir_q[p] ? pad_in[EV]   : pad_in[OD];
    assign loop_val = type_q[p] ? drv_pin : drv_val;

    assign cap_in[EV] = (en_q[p] && !dir_q[p]) ? loop_val : pad_in[EV];
    assign cap_in[OD] = (en_q[p] &&  dir_q[p]) ? loop_val : pad_in[OD];
    assign pad_oe[EV] = en_q[p] ? (type_q[p] &&  dir_q[p]) : core_oe[EV];
    assign pad_oe[OD] = en_q[p] ? (type_q[p] && !dir_q[p]) : core_oe[OD];

    // R5
    dig_no_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[p] && !type_q[p]) |-> (pad_oe[OD:EV] == 2'b00));

    // R4
    dig_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[p] && !type_q[p]) |->
        (dir_q[p] ? (cap_in[OD] == core_out[EV]) : (cap_in[EV] == core_out[OD])));

    // R6
    pad_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[p] && type_q[p]) |->
        ($countones(pad_oe[OD:EV]) == 1 &&
         (dir_q[p] ? (pad_oe[EV] && cap_in[OD] == pad_in[EV])
                   : (pad_oe[OD] && cap_in[EV] == pad_in[OD]))));

    // R2
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[p] |-> (cap_in[OD:EV] == pad_in[OD:EV] && pad_oe[OD:EV] == core_oe[OD:EV]));
  end

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ($stable(en_q) && $stable(dir_q) && $stable(type_q)));

  // R8
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (en_q == $past(cfg_en) && dir_q == $past(cfg_dir) && type_q == $past(cfg_type)));

endmodule

// File: tb/pair_loopback_router_bench.sv
module pair_loopback_router_bench;
  localparam int NP = 4;
  localparam int NC = 2 * NP;

  logic clk = 0, rst_n = 0, cfg_wr = 0;
  logic [NP-1:0] cfg_en = '0, cfg_dir = '0, cfg_type = '0;
  logic [NC-1:0] core_out = '0, core_oe = '0, pad_in = '0;
  logic [NC-1:0] cap_in, pad_out, pad_oe;

  logic [NP-1:0] m_en = '0, m_dir = '0, m_type = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pair_loopback_router #(.NPAIRS(NP)) u_pair_loopback_router (
    .clk, .rst_n, .cfg_wr, .cfg_en, .cfg_dir, .cfg_type,
    .core_out, .core_oe, .pad_in, .cap_in, .pad_out, .pad_oe);

  function automatic bit exp_cap(int c);
    int p = c / 2;
    bit odd = c[0];
    bit rcv = m_en[p] && (odd == m_dir[p]);
    int d = m_dir[p] ? 2 * p : 2 * p + 1;
    if (!rcv) return pad_in[c];
    return m_type[p] ? pad_in[d] : core_out[d];
  endfunction

  function automatic bit exp_oe(int c);
    int p = c / 2;
    bit odd = c[0];
    if (!m_en[p]) return core_oe[c];
    return m_type[p] && (odd != m_dir[p]);
  endfunction

  function automatic string tag(int c);
    int p = c / 2;
    bit odd = c[0];
    if (!m_en[p]) return "R2";
    if (odd != m_dir[p]) return "R7";
    if (m_dir[p]) return "R3";
    return m_type[p] ? "R6" : "R4";
  endfunction

  task automatic check_all(string note);
    for (int c = 0; c < NC; c++) begin
      checks++;
      if (cap_in[c] !== exp_cap(c)) begin
        fails++;
        $display("FAIL %s cap_in[%0d] %s: got %b exp %b", tag(c), c, note, cap_in[c], exp_cap(c));
      end
      checks++;
      if (pad_oe[c] !== exp_oe(c)) begin
        fails++;
        $display("FAIL %s pad_oe[%0d] %s: got %b exp %b",
                 (m_en[c/2] && !m_type[c/2]) ? "R5" : (m_en[c/2] ? "R6" : "R2"),
                 c, note, pad_oe[c], exp_oe(c));
      end
      checks++;
      if (pad_out[c] !== core_out[c]) begin
        fails++;
        $display("FAIL R2 pad_out[%0d] %s: got %b exp %b", c, note, pad_out[c], core_out[c]);
      end
    end
  endtask

  task automatic step(bit wr, logic [NP-1:0] en, logic [NP-1:0] dir, logic [NP-1:0] ty,
                      logic [NC-1:0] co, logic [NC-1:0] oe, logic [NC-1:0] pi, string note);
    @(negedge clk);
    cfg_wr = wr; cfg_en = en; cfg_dir = dir; cfg_type = ty;
    core_out = co; core_oe = oe; pad_in = pi;
    @(posedge clk);
    if (wr) begin m_en = en; m_dir = dir; m_type = ty; end
    #2;
    check_all(note);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    // R9: state after reset behaves as bypass
    core_out = 8'hA5; core_oe = 8'h3C; pad_in = 8'h5A;
    #3; check_all("R9 in reset");
    @(negedge clk); rst_n = 1;
    step(0, '1, '1, '1, 8'h0F, 8'hF0, 8'h33, "R9 after reset");
    // R8: no strobe, no change
    step(0, 4'hF, 4'h0, 4'h0, 8'hAA, 8'hFF, 8'h55, "R8 no strobe");
    // R4 R5: digital, odd drives even
    step(1, 4'hF, 4'h0, 4'h0, 8'hAA, 8'hFF, 8'h00, "R4 digital dir0");
    step(0, 4'h0, 4'h0, 4'h0, 8'h55, 8'hFF, 8'hFF, "R4 digital data change");
    // R3: digital, even drives odd
    step(1, 4'hF, 4'hF, 4'h0, 8'h55, 8'h00, 8'hAA, "R3 digital dir1");
    // R6: pad path both directions
    step(1, 4'hF, 4'h0, 4'hF, 8'h99, 8'h00, 8'hC3, "R6 pad dir0");
    step(1, 4'hF, 4'hF, 4'hF, 8'h66, 8'h00, 8'h3C, "R6 pad dir1");
    // R1: only pair 1 enabled, neighbours untouched
    step(1, 4'h2, 4'h2, 4'h0, 8'hFF, 8'hA5, 8'h00, "R1 single pair");
    step(0, 4'h0, 4'h0, 4'h0, 8'h00, 8'h5A, 8'hFF, "R1 single pair data");
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) == 0, NP'($urandom), NP'($urandom), NP'($urandom),
           NC'($urandom), NC'($urandom), NC'($urandom), "random");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule